// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the bus-facing half of a small byte-wide nonvolatile memory model on a two-wire serial bus. It watches the bus clock and data lines with a fast system clock, finds start and stop conditions, and shifts bytes in on rising bus-clock edges and out after falling ones. It checks the device address word, acknowledges bytes by pulling the data line low, and runs byte and page writes as well as current-address, random and sequential reads. Storage and the timed programming cycle belong to a neighbouring controller. The engine reaches that controller through a small byte port: a read request with an address, a write strobe for each data byte, and a commit pulse when a write transaction closes cleanly.

The memory depth is set by `MEM_ADDR_BITS`, from 7 to 11. Call P = max(0, MEM_ADDR_BITS - 8). Bits 3 down to P+1 of the device address word are compared against the hard-wired address pins. Bits P down to 1 carry the top memory address bits. The engine holds the word address counter, so a read that gives no address continues from where the last access stopped.

Top module: `twowire_eeprom_target`

## Requirements
- R1: After reset the data line is released (`sda_oe`=0), `mem_rd_req`, `mem_wr_en` and `mem_wr_commit` are 0, `mem_addr` is 0, and the engine ignores the bus until a start.
- R2: Bytes go MSB first. `sda_oe` rises only while the synchronized bus clock is low. A data-line change while the bus clock is high is a start (falling) or a stop (rising).
- R3: A device word is accepted only if bits 7..4 are 1010 and bits 3..P+1 equal `pin_addr` at the same positions. With the default of 9, bits 3..2 are compared with `pin_addr[2:1]`, and `pin_addr[0]` has no effect. On a mismatch the engine leaves the line released and waits for the next start.
- R4: The engine pulls the data line low through the ninth clock after each matched device word, each word address byte and each write data byte.
- R5: Each complete write data byte gives one `mem_wr_en` pulse. The pulse carries `mem_wr_data` and the target `mem_addr`.
- R6: When bit 0 of the device word is 1 the engine reads. It pulses `mem_rd_req` and sends `mem_rd_data`, which must be valid from the cycle after the request.
- R7: While `wr_busy` is high at the end of a device word, the engine does not acknowledge it. Once `wr_busy` is low it acknowledges normally.
- R8: In a write, the address advances only in its low page bits (3 when `MEM_ADDR_BITS` is at most 8, otherwise 4) and wraps within the page.
- R9: A read keeps sending the next byte while the controller acknowledges. The full address wraps from all ones to zero. A missing acknowledge ends the read.
- R10: A stop that comes after at least one data byte, with at most one bit of a further byte clocked, gives one `mem_wr_commit` pulse. A stop with 2 to 8 bits of a byte clocked commits nothing.
- R11: The address counter is kept between transactions and equals the last accessed address plus one. The page bits of a read device word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock sample |
| sda_i | input | 1 | Bus data sample |
| sda_oe | output | 1 | 1 pulls the data line low |
| pin_addr | input | 3 | Hard-wired device address pins |
| wr_busy | input | 1 | Controller is in its timed write cycle |
| mem_addr | output | MEM_ADDR_BITS | Word address for reads and writes |
| mem_rd_req | output | 1 | One-cycle read request |
| mem_rd_data | input | 8 | Read byte from the controller |
| mem_wr_en | output | 1 | One-cycle write byte strobe |
| mem_wr_data | output | 8 | Write byte |
| mem_wr_commit | output | 1 | Clean end of a write transaction |

## Verification
The hardest case to reach is a stop that lands part way into a data byte after earlier bytes have already gone to the controller. The stop's own clock rise counts as a bit, so the bench clocks three bits of the next byte and then stops. It then checks that no commit appears and reads the location back unchanged. A second hard case is acknowledge polling, because it depends on bus time against the controller's busy window. The bench sends a device word right after a commit, while the modelled busy counter is still running, and sends it again after the counter has drained.

// File: rtl/twowire_eeprom_target.sv
module twowire_eeprom_target #(
  parameter int MEM_ADDR_BITS = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe,
  input  logic [2:0]               pin_addr,
  input  logic                     wr_busy,
  output logic [MEM_ADDR_BITS-1:0] mem_addr,
  output logic                     mem_rd_req,
  input  logic [7:0]               mem_rd_data,
  output logic                     mem_wr_en,
  output logic [7:0]               mem_wr_data,
  output logic                     mem_wr_commit
);
  localparam int PG_BITS   = (MEM_ADDR_BITS > 8) ? MEM_ADDR_BITS - 8 : 0;
  localparam int PGW       = (PG_BITS > 0) ? PG_BITS : 1;
  localparam int PAGE_BITS = (MEM_ADDR_BITS > 8) ? 4 : 3;
  localparam logic [2:0] CMP_MASK = 3'b111 << PG_BITS;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WORD, S_WDATA, S_RDATA} st_t;

  logic [1:0] scl_sync, sda_sync;
  logic       scl_q, sda_q;
  st_t        st;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic       rw, wrote;
  logic [PGW-1:0] pg_q;
  logic [MEM_ADDR_BITS-1:0] word_addr, addr_pinc;

  wire scl_s    = scl_sync[1];
  wire sda_s    = sda_sync[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_ev = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
  wire dev_ok   = (shreg[7:4] == 4'b1010) &&
                  (((shreg[3:1] ^ pin_addr) & CMP_MASK) == 3'b000) && !wr_busy;

  generate
    if (MEM_ADDR_BITS > 8) begin : g_pg
      assign word_addr = {pg_q, shreg};
    end else begin : g_nopg
      assign word_addr = shreg[MEM_ADDR_BITS-1:0];
    end
  endgenerate

  assign addr_pinc = {mem_addr[MEM_ADDR_BITS-1:PAGE_BITS],
                      mem_addr[PAGE_BITS-1:0] + PAGE_BITS'(1)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      bitcnt        <= 4'd0;
      shreg         <= 8'd0;
      rw            <= 1'b0;
      wrote         <= 1'b0;
      pg_q          <= '0;
      sda_oe        <= 1'b0;
      mem_addr      <= '0;
      mem_rd_req    <= 1'b0;
      mem_wr_en     <= 1'b0;
      mem_wr_data   <= 8'd0;
      mem_wr_commit <= 1'b0;
    end else begin
      mem_rd_req    <= 1'b0;
      mem_wr_en     <= 1'b0;
      mem_wr_commit <= 1'b0;
      if (start_ev) begin
        st     <= S_DEV;
        bitcnt <= 4'd0;
        sda_oe <= 1'b0;
        wrote  <= 1'b0;
      end else if (stop_ev) begin
        if (st == S_WDATA && wrote && bitcnt <= 4'd1) mem_wr_commit <= 1'b1;
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (st == S_RDATA) begin
            if (bitcnt == 4'd8) begin
              if (sda_s) st <= S_IDLE;
              else begin
                mem_rd_req <= 1'b1;
                bitcnt     <= 4'd9;
              end
            end else begin
              bitcnt <= bitcnt + 4'd1;
            end
          end else if (bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (bitcnt == 4'd8) begin
            bitcnt <= 4'd9;
          end
        end else if (scl_fall) begin
          if (st == S_RDATA) begin
            if (bitcnt == 4'd8) begin
              sda_oe   <= 1'b0;
              mem_addr <= mem_addr + MEM_ADDR_BITS'(1);
            end else if (bitcnt == 4'd9) begin
              shreg  <= mem_rd_data;
              sda_oe <= ~mem_rd_data[7];
              bitcnt <= 4'd0;
            end else if (bitcnt != 4'd0) begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
            end
          end else if (bitcnt == 4'd8) begin
            case (st)
              S_DEV: begin
                if (dev_ok) begin
                  sda_oe     <= 1'b1;
                  rw         <= shreg[0];
                  pg_q       <= PGW'(shreg[3:1]);
                  mem_rd_req <= shreg[0];
                end else begin
                  st <= S_IDLE;
                end
              end
              S_WORD: begin
                sda_oe   <= 1'b1;
                mem_addr <= word_addr;
              end
              S_WDATA: begin
                sda_oe      <= 1'b1;
                mem_wr_en   <= 1'b1;
                mem_wr_data <= shreg;
                wrote       <= 1'b1;
              end
              default: ;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt <= 4'd0;
            sda_oe <= 1'b0;
            case (st)
              S_DEV: begin
                if (rw) begin
                  st     <= S_RDATA;
                  shreg  <= mem_rd_data;
                  sda_oe <= ~mem_rd_data[7];
                end else begin
                  st <= S_WORD;
                end
              end
              S_WORD:  st <= S_WDATA;
              S_WDATA: mem_addr <= addr_pinc;
              default: ;
            endcase
          end
        end
      end
    end
  end

  assert_oe_rise_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_rd_req_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);

  assert_wr_rd_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_en && mem_rd_req));

  assert_page_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WDATA && $past(st) == S_WDATA && !$stable(mem_addr)) |->
    mem_addr[MEM_ADDR_BITS-1:PAGE_BITS] == $past(mem_addr[MEM_ADDR_BITS-1:PAGE_BITS]));

  assert_commit_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_commit |-> (st == S_IDLE && !sda_oe));
endmodule

// File: tb/test_twowire_eeprom_target.sv
module test_twowire_eeprom_target;
  localparam int CLK_PERIOD = 10;
  localparam int MAB = 9;
  localparam int DEPTH = 1 << MAB;
  localparam int BUSY_CYC = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, mem_rd_req, mem_wr_en, mem_wr_commit;
  logic [2:0] pin_addr = 3'b101;
  logic wr_busy;
  logic [MAB-1:0] mem_addr;
  logic [7:0] mem_rd_data = 8'h00, mem_wr_data;
  wire sda_bus = m_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  twowire_eeprom_target #(.MEM_ADDR_BITS(MAB)) i_twowire_eeprom_target (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .pin_addr(pin_addr), .wr_busy(wr_busy), .mem_addr(mem_addr),
    .mem_rd_req(mem_rd_req), .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
    .mem_wr_data(mem_wr_data), .mem_wr_commit(mem_wr_commit));

  int n_chk = 0, n_bad = 0, n_commit = 0, busy_cnt = 0;
  bit done = 0;
  logic [7:0] mem [DEPTH];
  logic [7:0] exp_mem [DEPTH];
  logic [MAB+7:0] stage_q[$];
  logic [MAB+7:0] exp_wr[$];
  assign wr_busy = (busy_cnt != 0);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory controller model plus scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd_req) begin
        mem_rd_data = mem[mem_addr];
        stage_q.delete();
      end
      if (mem_wr_en) begin
        stage_q.push_back({mem_addr, mem_wr_data});
        if (exp_wr.size() == 0) check("R5", {mem_addr, mem_wr_data}, 0, "unexpected write strobe");
        else check("R5 R8", {mem_addr, mem_wr_data}, exp_wr.pop_front(), "write strobe addr/data");
      end
      if (mem_wr_commit) begin
        foreach (stage_q[i]) mem[stage_q[i][MAB+7:8]] = stage_q[i][7:0];
        stage_q.delete();
        n_commit++;
        busy_cnt = BUSY_CYC;
      end else if (busy_cnt > 0) busy_cnt--;
    end
  end

  task automatic wt(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(4); m_scl = 1'b1; wt(4); m_sda = 1'b0; wt(4); m_scl = 1'b0; wt(4);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(4); m_scl = 1'b1; wt(4); m_sda = 1'b1; wt(8);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; wt(4); m_scl = 1'b1; wt(4); s = sda_bus; wt(4); m_scl = 1'b0; wt(4);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    logic s;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      b = {b[6:0], s};
    end
    clk_bit(~give_ack, s);
  endtask

  function automatic logic [7:0] dev_word(logic [2:0] pins, logic a8, logic rd);
    return {4'b1010, pins[2:1], a8, rd};
  endfunction

  task automatic wait_idle(); while (wr_busy) wt(1); wt(4); endtask

  // driver: write transaction, pushes expected strobes
  task automatic do_write(logic [MAB-1:0] a, logic [7:0] d[], string req);
    logic ack;
    logic [MAB-1:0] cur = a;
    bus_start();
    send_byte(dev_word(pin_addr, a[8], 1'b0), ack); check(req, ack, 1, "device word ack R4");
    send_byte(a[7:0], ack); check(req, ack, 1, "word address ack R4");
    foreach (d[i]) begin
      exp_wr.push_back({cur, d[i]});
      send_byte(d[i], ack); check(req, ack, 1, "data ack R4");
      cur = {cur[MAB-1:4], cur[3:0] + 4'd1};
    end
    bus_stop();
  endtask

  task automatic set_addr(logic [MAB-1:0] a);
    logic ack;
    bus_start();
    send_byte(dev_word(pin_addr, a[8], 1'b0), ack); check("R6", ack, 1, "dummy write ack");
    send_byte(a[7:0], ack); check("R6", ack, 1, "dummy word ack");
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    int c0;
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 8'(i * 37 + 5);
      exp_mem[i] = mem[i];
    end
    wt(5); rst_n = 1'b1; wt(3);
    // R1 reset state
    check("R1", sda_oe, 0, "sda_oe after reset");
    check("R1", {mem_rd_req, mem_wr_en, mem_wr_commit}, 0, "strobes after reset");
    check("R1", mem_addr, 0, "address after reset");

    // R3 wrong prefix and wrong pin
    bus_start(); send_byte(8'b1011_1010, ack); check("R3", ack, 0, "bad prefix nack"); bus_stop();
    bus_start(); send_byte({4'b1010, 2'b00, 1'b1, 1'b0}, ack); check("R3", ack, 0, "pin mismatch nack"); bus_stop();

    // R5 R10 byte write
    do_write(9'h123, '{8'h5A}, "R5");
    wt(2);
    check("R10", n_commit, 1, "commit after byte write");
    exp_mem[9'h123] = 8'h5A;

    // R7 acknowledge polling
    check("R7", wr_busy, 1, "controller busy");
    bus_start(); send_byte(dev_word(pin_addr, 1'b0, 1'b0), ack); check("R7", ack, 0, "nack while busy"); bus_stop();
    wait_idle();
    bus_start(); send_byte(dev_word(pin_addr, 1'b0, 1'b0), ack); check("R7", ack, 1, "ack after busy"); bus_stop();
    wt(2);
    check("R10", n_commit, 1, "no commit without data");

    // R6 random read, R11 current read with ignored page bit
    set_addr(9'h123);
    bus_start(); send_byte(dev_word(pin_addr, 1'b0, 1'b1), ack); check("R6", ack, 1, "read word ack");
    recv_byte(b, 1'b0); check("R6 R2", b, exp_mem[9'h123], "random read byte"); bus_stop();
    bus_start(); send_byte(dev_word(pin_addr, 1'b0, 1'b1), ack); check("R11", ack, 1, "current read ack");
    recv_byte(b, 1'b0); check("R11", b, exp_mem[9'h124], "current address read"); bus_stop();

    // R8 page write wrapping inside a 16-byte page
    do_write(9'h1FE, '{8'hA1, 8'hA2, 8'hA3, 8'hA4}, "R8");
    wt(2);
    check("R10", n_commit, 2, "commit after page write");
    exp_mem[9'h1FE] = 8'hA1; exp_mem[9'h1FF] = 8'hA2;
    exp_mem[9'h1F0] = 8'hA3; exp_mem[9'h1F1] = 8'hA4;
    wait_idle();

    // R9 sequential read across full rollover
    set_addr(9'h1FE);
    bus_start(); send_byte(dev_word(pin_addr, 1'b1, 1'b1), ack); check("R9", ack, 1, "seq read ack");
    recv_byte(b, 1'b1); check("R9", b, exp_mem[9'h1FE], "seq byte 0");
    recv_byte(b, 1'b1); check("R9", b, exp_mem[9'h1FF], "seq byte 1");
    recv_byte(b, 1'b1); check("R9", b, exp_mem[9'h000], "seq byte rollover");
    recv_byte(b, 1'b0); check("R9", b, exp_mem[9'h001], "seq byte 3");
    bus_stop();
    check("R9", sda_oe, 0, "released after nack");
    set_addr(9'h1F0);
    bus_start(); send_byte(dev_word(pin_addr, 1'b1, 1'b1), ack);
    recv_byte(b, 1'b0); check("R8", b, 8'hA3, "page wrap byte at page start"); bus_stop();

    // R10 stop in the middle of a byte
    c0 = n_commit;
    begin
      logic s;
      bus_start();
      send_byte(dev_word(pin_addr, 1'b0, 1'b0), ack);
      send_byte(8'h50, ack);
      exp_wr.push_back({9'h050, 8'h77});
      send_byte(8'h77, ack); check("R10", ack, 1, "data ack before abort");
      for (int i = 0; i < 3; i++) clk_bit(1'b1, s);
      bus_stop();
    end
    wt(4);
    check("R10", n_commit, c0, "no commit on mid-byte stop");
    set_addr(9'h050);
    bus_start(); send_byte(dev_word(pin_addr, 1'b0, 1'b1), ack);
    recv_byte(b, 1'b0); check("R10", b, exp_mem[9'h050], "aborted byte not stored"); bus_stop();

    // R3 uncompared pin ignored, compared pin honoured
    pin_addr = 3'b100;
    bus_start(); send_byte({4'b1010, 2'b10, 1'b0, 1'b1}, ack); check("R3", ack, 1, "pin bit 0 ignored");
    recv_byte(b, 1'b0); bus_stop();
    pin_addr = 3'b110;
    bus_start(); send_byte({4'b1010, 2'b10, 1'b0, 1'b1}, ack); check("R3", ack, 0, "pin bit 1 compared"); bus_stop();

    wt(10);
    check("R5", exp_wr.size(), 0, "all expected write strobes seen");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule